// File: doc/BRIEF.md
# SPI Transfer Queue Sequencer

This block walks a small queue of serial transfers. Each queue entry has three parts: a command word, a transmit word and a receive word. All three are held in internal arrays of 2^PTR_W entries. Before a run, software fills the command and transmit arrays through a table-load port. The sequencer then hands one entry at a time to an external transfer executor, which does the actual shifting. The sequencer waits for the executor's completion pulse and stores the returned word in the receive array. Software reads the receive array back through a read port.

After each transfer the sequencer reports the index of the entry just finished and picks the next entry. It normally moves to the following entry. If software wrote a new queue pointer during the transfer, the run jumps to that entry instead. When the entry equal to the end-queue pointer finishes, a sticky finished flag is set, and an interrupt request follows if it is enabled. The run then either halts, which clears the enable bit, or wraps around. A wrap goes to entry 0 or to the software pointer, chosen by a select input.

Top module: `spi_queue_seq`

## Requirements
- R1: Writing the enable bit from 0 to 1 (`en_we`=1, `en_wdata`=1) starts a run at entry `newqp`. Two clock edges after the write, `xfer_req` is high and `xfer_cmd`/`xfer_tx` carry that entry's contents.
- R2: One cycle after the executor completes a transfer (`xfer_req` and `xfer_done` both high), `cptqp` equals the index of that entry. Unless R4 or R8 redirects the run, the next transfer uses index+1, wrapping modulo 2^PTR_W.
- R3: The word on `xfer_rx` at completion is stored in the receive array at the completed entry's index, and `rx_rdata` shows it combinationally for `rx_addr`.
- R4: A `newqp_we` pulse during a transfer does not cut that transfer short. The next transfer then starts at the written `newqp` instead of the incremented index.
- R5: Completing the entry whose index equals `endqp` sets `fin`. `fin` stays at 1 until a cycle with `fin_clr`=1.
- R6: `irq` is 1 exactly when `fin` is 1 and `irq_en` is 1.
- R7: Completing the end entry with `wrap_en`=0 clears `q_enable`, and no further transfer is requested.
- R8: Completing the end entry with `wrap_en`=1 keeps the run going. The next entry is 0 when `wrap_to`=0 and `newqp` when `wrap_to`=1.
- R9: Writing 0 to the enable bit during a transfer lets that transfer complete: its receive word and `cptqp` are updated. No further transfer follows.
- R10: `xfer_req` stays high until `xfer_done` is seen. After each completion it is low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table-load write strobe |
| tbl_addr | input | PTR_W | Entry index for table load |
| tbl_cmd | input | CMD_W | Command word to store |
| tbl_tx | input | DATA_W | Transmit word to store |
| rx_addr | input | PTR_W | Receive array read index |
| rx_rdata | output | DATA_W | Receive word at `rx_addr` |
| en_we | input | 1 | Enable bit write strobe |
| en_wdata | input | 1 | Enable bit write value |
| newqp | input | PTR_W | Software queue pointer |
| newqp_we | input | 1 | Strobe marking a write of `newqp` |
| endqp | input | PTR_W | Index of the last queue entry |
| wrap_en | input | 1 | Wraparound enable |
| wrap_to | input | 1 | Wrap target: 0 = entry 0, 1 = `newqp` |
| irq_en | input | 1 | Interrupt enable |
| fin_clr | input | 1 | Write-1 clear of the finished flag |
| xfer_req | output | 1 | Transfer request to the executor |
| xfer_cmd | output | CMD_W | Command word of the current entry |
| xfer_tx | output | DATA_W | Transmit word of the current entry |
| xfer_done | input | 1 | Executor completion pulse |
| xfer_rx | input | DATA_W | Received word, valid with `xfer_done` |
| q_enable | output | 1 | Current value of the enable bit |
| cptqp | output | PTR_W | Index of the last completed entry |
| fin | output | 1 | Finished flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: PTR_W=4 (16 entries), DATA_W=16 and CMD_W=8. With 16 entries, a wrap from the top entry 15 back to entry 0 happens within a five-transfer run. A redirect that jumps backwards from entry 11 to entry 2 fits in a single pass. With 16-bit data, every transmit word can encode its own index, so the scoreboard can identify each entry from the executor side alone. Each transfer is held for three cycles, which leaves a window for pointer writes and enable clears mid-transfer.

// File: rtl/qs_pkg.sv
package qs_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } qs_state_e;
endpackage

// File: rtl/qs_store.sv
// Small entry array: one synchronous write port, one combinational read port.
module qs_store #(
    parameter int AW = 4,
    parameter int W  = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/qs_ptr_next.sv
// Chooses the entry that follows a completed transfer.
module qs_ptr_next #(
    parameter int PTR_W = 4
) (
    input  logic [PTR_W-1:0] wp,
    input  logic [PTR_W-1:0] endqp,
    input  logic [PTR_W-1:0] newqp,
    input  logic             redirect,
    input  logic             wrap_en,
    input  logic             wrap_to,
    output logic [PTR_W-1:0] nxt,
    output logic             at_end,
    output logic             halt
);
    localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    always_comb begin
        at_end = (wp == endqp);
        halt   = at_end && !wrap_en;
        if (at_end) begin
            if (!wrap_en) begin
                nxt = wp + ONE;
            end else if (wrap_to) begin
                nxt = newqp;
            end else begin
                nxt = '0;
            end
        end else if (redirect) begin
            nxt = newqp;
        end else begin
            nxt = wp + ONE;
        end
    end
endmodule

// File: rtl/spi_queue_seq.sv
module spi_queue_seq
    import qs_pkg::*;
#(
    parameter int PTR_W  = 4,
    parameter int DATA_W = 16,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [PTR_W-1:0]  tbl_addr,
    input  logic [CMD_W-1:0]  tbl_cmd,
    input  logic [DATA_W-1:0] tbl_tx,
    input  logic [PTR_W-1:0]  rx_addr,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              en_we,
    input  logic              en_wdata,
    input  logic [PTR_W-1:0]  newqp,
    input  logic              newqp_we,
    input  logic [PTR_W-1:0]  endqp,
    input  logic              wrap_en,
    input  logic              wrap_to,
    input  logic              irq_en,
    input  logic              fin_clr,
    output logic              xfer_req,
    output logic [CMD_W-1:0]  xfer_cmd,
    output logic [DATA_W-1:0] xfer_tx,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] xfer_rx,
    output logic              q_enable,
    output logic [PTR_W-1:0]  cptqp,
    output logic              fin,
    output logic              irq
);
    typedef struct packed {
        qs_state_e        st;
        logic             en;
        logic             pend;
        logic             fin;
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] cpt;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             complete;
    logic [PTR_W-1:0] nxt_ptr;
    logic             at_end;
    logic             halt;
    logic [PTR_W-1:0] wp_cur;
    logic             pend_cur;

    assign complete = (seq_q.st == ST_XFER) && xfer_done;
    assign wp_cur   = seq_q.wp;
    assign pend_cur = seq_q.pend;

    qs_store #(.AW(PTR_W), .W(CMD_W)) u_cmd (
        .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_cmd),
        .raddr(seq_q.wp), .rdata(xfer_cmd)
    );

    qs_store #(.AW(PTR_W), .W(DATA_W)) u_tx (
        .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_tx),
        .raddr(seq_q.wp), .rdata(xfer_tx)
    );

    qs_store #(.AW(PTR_W), .W(DATA_W)) u_rx (
        .clk(clk), .we(complete), .waddr(seq_q.wp), .wdata(xfer_rx),
        .raddr(rx_addr), .rdata(rx_rdata)
    );

    qs_ptr_next #(.PTR_W(PTR_W)) u_next (
        .wp(seq_q.wp), .endqp(endqp), .newqp(newqp),
        .redirect(seq_q.pend || newqp_we),
        .wrap_en(wrap_en), .wrap_to(wrap_to),
        .nxt(nxt_ptr), .at_end(at_end), .halt(halt)
    );

    always_comb begin
        seq_d = seq_q;
        if (en_we) begin
            seq_d.en = en_wdata;
        end
        if (fin_clr) begin
            seq_d.fin = 1'b0;
        end
        unique case (seq_q.st)
            ST_IDLE: begin
                if (seq_q.en) begin
                    seq_d.st = ST_XFER;
                    if (newqp_we) begin
                        seq_d.wp = newqp;
                    end
                end else if (en_we && en_wdata) begin
                    seq_d.wp   = newqp;
                    seq_d.pend = 1'b0;
                end
            end
            ST_XFER: begin
                if (complete) begin
                    seq_d.cpt  = seq_q.wp;
                    seq_d.wp   = nxt_ptr;
                    seq_d.pend = 1'b0;
                    seq_d.st   = ST_IDLE;
                    if (at_end) begin
                        seq_d.fin = 1'b1;
                    end
                    if (halt) begin
                        seq_d.en = 1'b0;
                    end
                end else if (newqp_we) begin
                    seq_d.pend = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, en: 1'b0, pend: 1'b0, fin: 1'b0,
                       wp: '0, cpt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign xfer_req = (seq_q.st == ST_XFER);
    assign q_enable = seq_q.en;
    assign cptqp    = seq_q.cpt;
    assign fin      = seq_q.fin;
    assign irq      = seq_q.fin && irq_en;
endmodule

// File: rtl/spi_queue_seq_chk.sv
module spi_queue_seq_chk #(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_req,
    input logic             xfer_done,
    input logic [PTR_W-1:0] wp,
    input logic             pend,
    input logic [PTR_W-1:0] cptqp,
    input logic [PTR_W-1:0] endqp,
    input logic [PTR_W-1:0] newqp,
    input logic             newqp_we,
    input logic             wrap_en,
    input logic             wrap_to,
    input logic             fin,
    input logic             fin_clr,
    input logic             irq,
    input logic             irq_en,
    input logic             q_enable
);
    localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_done |=> xfer_req);

    p_req_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_done |=> !xfer_req);

    p_cpt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_done |=> cptqp == $past(wp));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_done && (wp != endqp) && !pend && !newqp_we
        |=> wp == $past(wp) + ONE);

    p_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_done && (wp != endqp) && (pend || newqp_we)
        |=> wp == $past(newqp));

    p_fin_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_done && (wp == endqp) |=> fin);

    p_fin_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fin && !fin_clr |=> fin);

    p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fin && irq_en);

    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_done && (wp == endqp) && !wrap_en |=> !q_enable);

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_done && (wp == endqp) && wrap_en && !wrap_to
        |=> wp == '0);
endmodule

bind spi_queue_seq spi_queue_seq_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_done(xfer_done),
    .wp(wp_cur), .pend(pend_cur), .cptqp(cptqp), .endqp(endqp),
    .newqp(newqp), .newqp_we(newqp_we), .wrap_en(wrap_en), .wrap_to(wrap_to),
    .fin(fin), .fin_clr(fin_clr), .irq(irq), .irq_en(irq_en),
    .q_enable(q_enable)
);

// File: tb/sim_spi_queue_seq.sv
module sim_spi_queue_seq;
    localparam int PTR_W  = 4;
    localparam int DATA_W = 16;
    localparam int CMD_W  = 8;
    localparam int DEPTH  = 1 << PTR_W;

    logic              clk, rst_n;
    logic              tbl_we;
    logic [PTR_W-1:0]  tbl_addr;
    logic [CMD_W-1:0]  tbl_cmd;
    logic [DATA_W-1:0] tbl_tx;
    logic [PTR_W-1:0]  rx_addr;
    logic [DATA_W-1:0] rx_rdata;
    logic              en_we, en_wdata;
    logic [PTR_W-1:0]  newqp;
    logic              newqp_we;
    logic [PTR_W-1:0]  endqp;
    logic              wrap_en, wrap_to, irq_en, fin_clr;
    logic              xfer_req;
    logic [CMD_W-1:0]  xfer_cmd;
    logic [DATA_W-1:0] xfer_tx;
    logic              xfer_done;
    logic [DATA_W-1:0] xfer_rx;
    logic              q_enable;
    logic [PTR_W-1:0]  cptqp;
    logic              fin, irq;

    spi_queue_seq #(.PTR_W(PTR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_cmd(tbl_cmd), .tbl_tx(tbl_tx), .rx_addr(rx_addr),
        .rx_rdata(rx_rdata), .en_we(en_we), .en_wdata(en_wdata),
        .newqp(newqp), .newqp_we(newqp_we), .endqp(endqp),
        .wrap_en(wrap_en), .wrap_to(wrap_to), .irq_en(irq_en),
        .fin_clr(fin_clr), .xfer_req(xfer_req), .xfer_cmd(xfer_cmd),
        .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx),
        .q_enable(q_enable), .cptqp(cptqp), .fin(fin), .irq(irq)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int n_start = 0;
    int cur_idx = 0;
    int wait_cnt = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int tx_of(input int k);
        return 32'h1000 + k;
    endfunction

    function automatic int rx_of(input int k);
        return (32'h1000 + k) ^ 32'h5A5A;
    endfunction

    // Executor model and scoreboard monitor
    always @(negedge clk) begin : mon
        int e;
        if (xfer_done) begin
            xfer_done = 1'b0;
            check(int'(cptqp) == cur_idx, "R2", "completed pointer",
                  int'(cptqp), cur_idx);
        end else if (xfer_req) begin
            if (wait_cnt == 0) begin
                n_start++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected transfer", int'(xfer_tx), 0);
                end else begin
                    e = exp_q.pop_front();
                    cur_idx = e;
                    check(int'(xfer_tx) == tx_of(e), "R2", "entry order tx",
                          int'(xfer_tx), tx_of(e));
                    check(int'(xfer_cmd) == ((32'h40 + e) & 32'hFF), "R1",
                          "command word", int'(xfer_cmd), (32'h40 + e) & 32'hFF);
                end
            end
            if (wait_cnt == 2) begin
                xfer_done = 1'b1;
                xfer_rx   = xfer_tx ^ 16'h5A5A;
                wait_cnt  = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic push_seq(input int a, input int b);
        for (int k = a; k <= b; k++) exp_q.push_back(k);
    endtask

    task automatic wr_en(input logic v);
        @(negedge clk);
        en_we = 1'b1; en_wdata = v;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic clr_fin();
        @(negedge clk);
        fin_clr = 1'b1;
        @(negedge clk);
        fin_clr = 1'b0;
    endtask

    task automatic settle();
        do @(negedge clk); while (q_enable || xfer_req);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_rx(input int k, input string req);
        rx_addr = PTR_W'(k);
        #1;
        check(int'(rx_rdata) == rx_of(k), req, "receive word", int'(rx_rdata), rx_of(k));
    endtask

    task automatic check_quiet(input string req);
        int base;
        base = n_start;
        repeat (10) @(negedge clk);
        check(n_start == base, req, "transfers after stop", n_start - base, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        int base;
        rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_cmd = '0; tbl_tx = '0;
        rx_addr = '0; en_we = 1'b0; en_wdata = 1'b0; newqp = '0; newqp_we = 1'b0;
        endqp = '0; wrap_en = 1'b0; wrap_to = 1'b0; irq_en = 1'b0; fin_clr = 1'b0;
        xfer_done = 1'b0; xfer_rx = '0;
        repeat (3) @(negedge clk);
        check(xfer_req == 1'b0, "R10", "reset request", int'(xfer_req), 0);
        check(q_enable == 1'b0, "R1", "reset enable", int'(q_enable), 0);
        check(fin == 1'b0, "R5", "reset fin", int'(fin), 0);
        check(irq == 1'b0, "R6", "reset irq", int'(irq), 0);
        check(cptqp == '0, "R2", "reset cptqp", int'(cptqp), 0);
        rst_n = 1'b1;

        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            tbl_we = 1'b1; tbl_addr = PTR_W'(k);
            tbl_cmd = CMD_W'(32'h40 + k); tbl_tx = DATA_W'(tx_of(k));
        end
        @(negedge clk);
        tbl_we = 1'b0;

        // R1 R5 R6 R7: plain run 3..6, no wrap
        newqp = 4'd3; endqp = 4'd6; irq_en = 1'b1;
        push_seq(3, 6);
        wr_en(1'b1);
        @(negedge clk);
        check(xfer_req == 1'b1, "R1", "request after enable", int'(xfer_req), 1);
        check(int'(xfer_tx) == tx_of(3), "R1", "first entry tx", int'(xfer_tx), tx_of(3));
        settle();
        check(exp_q.size() == 0, "R2", "entries left", exp_q.size(), 0);
        check(q_enable == 1'b0, "R7", "enable after end", int'(q_enable), 0);
        check(fin == 1'b1, "R5", "fin after end", int'(fin), 1);
        check(irq == 1'b1, "R6", "irq with enable", int'(irq), 1);
        check(int'(cptqp) == 6, "R2", "last completed", int'(cptqp), 6);
        check_quiet("R7");
        check_rx(4, "R3");
        check_rx(6, "R3");
        irq_en = 1'b0;
        #1;
        check(irq == 1'b0, "R6", "irq masked", int'(irq), 0);
        check(fin == 1'b1, "R5", "fin sticky", int'(fin), 1);
        clr_fin();
        check(fin == 1'b0, "R5", "fin cleared", int'(fin), 0);

        // R4: redirect to entry 2 during transfer of entry 11
        irq_en = 1'b1;
        newqp = 4'd10; endqp = 4'd13;
        exp_q.push_back(10); exp_q.push_back(11);
        push_seq(2, 13);
        base = n_start;
        wr_en(1'b1);
        do @(negedge clk); while (n_start < base + 2);
        newqp = 4'd2; newqp_we = 1'b1;
        @(negedge clk);
        newqp_we = 1'b0;
        settle();
        check(exp_q.size() == 0, "R4", "redirect entries left", exp_q.size(), 0);
        check(int'(cptqp) == 13, "R4", "last completed", int'(cptqp), 13);
        check(irq == 1'b1, "R6", "irq after redirect run", int'(irq), 1);
        check_rx(11, "R3");
        clr_fin();
        check(irq == 1'b0, "R6", "irq after clear", int'(irq), 0);

        // R8 wrap to 0, then R9 stop by enable clear
        irq_en = 1'b0; newqp = 4'd14; endqp = 4'd15; wrap_en = 1'b1; wrap_to = 1'b0;
        push_seq(14, 15);
        push_seq(0, 2);
        base = n_start;
        wr_en(1'b1);
        do @(negedge clk); while (n_start < base + 5);
        en_we = 1'b1; en_wdata = 1'b0;
        @(negedge clk);
        en_we = 1'b0;
        settle();
        check(exp_q.size() == 0, "R8", "wrap to zero entries left", exp_q.size(), 0);
        check(int'(cptqp) == 2, "R9", "completed after clear", int'(cptqp), 2);
        check(q_enable == 1'b0, "R9", "enable after clear", int'(q_enable), 0);
        check(fin == 1'b1, "R5", "fin after wrap", int'(fin), 1);
        check(irq == 1'b0, "R6", "irq disabled", int'(irq), 0);
        check_rx(2, "R9");
        check_quiet("R9");
        clr_fin();

        // R8 wrap to software pointer
        newqp = 4'd5; endqp = 4'd6; wrap_to = 1'b1;
        push_seq(5, 6); push_seq(5, 6); exp_q.push_back(5);
        base = n_start;
        wr_en(1'b1);
        do @(negedge clk); while (n_start < base + 5);
        en_we = 1'b1; en_wdata = 1'b0;
        @(negedge clk);
        en_we = 1'b0;
        settle();
        check(exp_q.size() == 0, "R8", "wrap to pointer entries left", exp_q.size(), 0);
        check(int'(cptqp) == 5, "R8", "completed after wrap", int'(cptqp), 5);
        check_quiet("R9");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule